// File: doc/BRIEF.md
# Serial Flash Instruction Sequencer

This block runs serial-flash transactions that are described by software rather than hard-wired. A small table holds sequences of 16-bit instruction slots; each slot names an operation, the number of data lines to use, and an 8-bit operand. Software fills the table through a word-wide write port, then starts a sequence by giving its index and a data byte count. The engine walks the slots in order and produces the chip select, the serial clock and up to four data lines.

The slots can send a command byte or an address/mode byte, insert idle dummy clocks, read data into a receive FIFO, or send data taken from a transmit FIFO. The data length comes from the start command, not from the slot operand. A sequence ends on a stop slot or after its eighth slot. The engine then raises a done flag, which drives an interrupt when enabled and which software clears by writing 1.

The serial clock runs at half the system clock. Output data changes while the serial clock is low and input data is captured on its rising edge.

Top module: `flash_seq_engine`

## Requirements
- R1: Table word `4*n + k` (k = 0..3) holds slots `2k` (bits 15:0) and `2k+1` (bits 31:16) of sequence n. Within a slot, bits 15:10 are the opcode, bits 9:8 the pad code and bits 7:0 the operand. After reset every word is zero, so every slot is a stop.
- R2: A start pulse while idle latches the sequence index from bits 27:24 and the data byte count from bits 15:0 of the start word. A start pulse while a sequence runs is ignored.
- R3: `cs_n` goes low at the first slot that is neither a stop nor an unknown opcode, and it stays low until the sequence ends. `sck` idles low and is high only while `cs_n` is low. Each serial clock lasts two system clocks, with output data stable while `sck` is low.
- R4: Pad code 0 uses one line (out on `io_out[0]`, in on `io_in[1]`). Pad code 1 uses `io[1:0]`, and pad codes 2 and 3 use `io[3:0]`. Bytes travel most significant bits first, and `io_oe` enables exactly the output lanes in use.
- R5: Opcode 1 (command) and opcode 4 (mode/address) each send their operand byte on the selected lanes.
- R6: Opcode 3 (dummy) gives as many serial clocks as its operand, capped at 64, with `io_oe` all zero.
- R7: Opcode 7 (read) receives the start count of bytes into the RX FIFO, in arrival order, and ignores its operand. A zero count skips the slot.
- R8: Opcode 8 (write) holds off until the TX FIFO has at least 16 bytes, then sends exactly the start count of bytes. Bytes left in the TX FIFO are discarded when the sequence ends.
- R9: Opcode 0 (stop) ends the sequence. Completing slot 7 ends it as well. Any other opcode is skipped without clocks.
- R10: The end of a sequence sets `done_flag`. Writing a flag word with bit 0 set clears it, and setting wins over clearing in the same cycle. `irq` is `done_flag` gated by `irq_en`.
- R11: After reset `cs_n` is 1, while `sck`, `io_oe`, `done_flag`, `irq` and `busy` are 0 and both FIFOs are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lut_we | input | 1 | Table word write strobe |
| lut_waddr | input | 6 | Table word index |
| lut_wdata | input | 32 | Table word data (two slots) |
| start_valid | input | 1 | Start pulse |
| start_word | input | 32 | Sequence index [27:24], byte count [15:0] |
| flag_we | input | 1 | Flag register write strobe |
| flag_wdata | input | 32 | Flag write data, bit 0 clears done |
| irq_en | input | 1 | Done interrupt enable |
| tx_push | input | 1 | Push one byte to the TX FIFO |
| tx_wdata | input | 8 | TX byte |
| tx_level | output | 6 | TX FIFO fill in bytes |
| rx_pop | input | 1 | Pop one byte from the RX FIFO |
| rx_rdata | output | 8 | RX FIFO head byte |
| rx_level | output | 6 | RX FIFO fill in bytes |
| done_flag | output | 1 | Sequence finished flag |
| irq | output | 1 | Interrupt request |
| busy | output | 1 | Sequence in progress |
| sck | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| io_out | output | 4 | Data line output values |
| io_oe | output | 4 | Data line output enables |
| io_in | input | 4 | Data line inputs |

## Verification
The assertions assume that software never reads more bytes than the RX FIFO can hold before it pops them. They also assume that a write sequence is given at least as many TX bytes as its count, and that nobody pushes into a full TX FIFO. The stimulus keeps every read count at four bytes or fewer, and it drains the RX FIFO after each run. It supplies exactly 16 TX bytes for a write of 5, so no pop ever hits an empty FIFO and no push hits a full one. The flash side is modelled by driving `io_in` only while `sck` is low, which matches the capture edge the checks rely on.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

  localparam logic [5:0] OPC_STOP  = 6'd0;
  localparam logic [5:0] OPC_CMD   = 6'd1;
  localparam logic [5:0] OPC_DUMMY = 6'd3;
  localparam logic [5:0] OPC_MODE  = 6'd4;
  localparam logic [5:0] OPC_READ  = 6'd7;
  localparam logic [5:0] OPC_WRITE = 6'd8;

  typedef struct packed {
    logic [5:0] op;
    logic [1:0] pad;
    logic [7:0] arg;
  } slot_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_XFER, ST_DUMMY, ST_TXWAIT, ST_END
  } seq_state_e;

  // output lanes enabled for a pad code
  function automatic logic [3:0] lane_mask(input logic [1:0] pad);
    case (pad)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

  // serial clocks needed to move one byte
  function automatic logic [3:0] clocks_per_byte(input logic [1:0] pad);
    case (pad)
      2'd0:    return 4'd8;
      2'd1:    return 4'd4;
      default: return 4'd2;
    endcase
  endfunction

  // most significant bits of the shift register placed on the lanes
  function automatic logic [3:0] lanes_out(input logic [7:0] sr, input logic [1:0] pad);
    case (pad)
      2'd0:    return {3'b000, sr[7]};
      2'd1:    return {2'b00, sr[7:6]};
      default: return sr[7:4];
    endcase
  endfunction

  function automatic logic [7:0] shift_out(input logic [7:0] sr, input logic [1:0] pad);
    case (pad)
      2'd0:    return {sr[6:0], 1'b0};
      2'd1:    return {sr[5:0], 2'b00};
      default: return {sr[3:0], 4'b0000};
    endcase
  endfunction

  function automatic logic [7:0] shift_in(input logic [7:0] sr, input logic [1:0] pad,
                                          input logic [3:0] io);
    case (pad)
      2'd0:    return {sr[6:0], io[1]};
      2'd1:    return {sr[5:0], io[1:0]};
      default: return {sr[3:0], io[3:0]};
    endcase
  endfunction

endpackage

// File: rtl/sfs_fifo.sv
module sfs_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 32,
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [LW-1:0]    level,
  output logic             empty,
  output logic             full
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [LW-1:0]    level_q;
  logic             do_push, do_pop;

  assign empty   = (level_q == '0);
  assign full    = (level_q == LW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rd_ptr];
  assign level   = level_q;

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      level_q <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + PW'(1);
      if (do_pop)  rd_ptr <= rd_ptr + PW'(1);
      level_q <= level_q + LW'(do_push) - LW'(do_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wr_ptr] <= wdata;
  end

  // R8: the engine never takes a byte the FIFO does not hold
  a_r8_pop_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R7: the stored count never passes the depth
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (level_q == LW'(DEPTH)));

endmodule

// File: rtl/sfs_lut.sv
module sfs_lut #(
  parameter int NUM_SEQ = 16,
  localparam int SEQ_W  = $clog2(NUM_SEQ),
  localparam int AW     = SEQ_W + 2,
  localparam int WORDS  = NUM_SEQ * 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [31:0]      wdata,
  input  logic [SEQ_W-1:0] rd_seq,
  input  logic [2:0]       rd_slot,
  output logic [15:0]      rd_instr
);
  logic [31:0] words_q [WORDS];
  logic [31:0] word;

  generate
    for (genvar g = 0; g < WORDS; g++) begin : g_word
      always_ff @(posedge clk) begin
        if (!rst_n)                       words_q[g] <= '0;
        else if (we && waddr == AW'(g))   words_q[g] <= wdata;
      end
    end
  endgenerate

  // four words per sequence, even slot in the low half
  assign word     = words_q[{rd_seq, rd_slot[2:1]}];
  assign rd_instr = rd_slot[0] ? word[31:16] : word[15:0];

endmodule

// File: rtl/flash_seq_engine.sv
module flash_seq_engine #(
  parameter int NUM_SEQ      = 16,
  parameter int FIFO_DEPTH   = 32,
  parameter int TX_START_MIN = 16,
  parameter int MAX_DUMMY    = 64,
  parameter int COUNT_W      = 16,
  localparam int SEQ_W  = $clog2(NUM_SEQ),
  localparam int LUT_AW = SEQ_W + 2,
  localparam int FLW    = $clog2(FIFO_DEPTH + 1),
  localparam int DCW    = $clog2(MAX_DUMMY + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lut_we,
  input  logic [LUT_AW-1:0] lut_waddr,
  input  logic [31:0]       lut_wdata,
  input  logic              start_valid,
  input  logic [31:0]       start_word,
  input  logic              flag_we,
  input  logic [31:0]       flag_wdata,
  input  logic              irq_en,
  input  logic              tx_push,
  input  logic [7:0]        tx_wdata,
  output logic [FLW-1:0]    tx_level,
  input  logic              rx_pop,
  output logic [7:0]        rx_rdata,
  output logic [FLW-1:0]    rx_level,
  output logic              done_flag,
  output logic              irq,
  output logic              busy,
  output logic              sck,
  output logic              cs_n,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  import sfs_pkg::*;

  function automatic logic [DCW-1:0] dummy_clocks(input logic [7:0] arg);
    if (int'(arg) > MAX_DUMMY) return DCW'(MAX_DUMMY);
    return DCW'(arg);
  endfunction

  seq_state_e         state_q;
  logic [SEQ_W-1:0]   seq_q;
  logic [2:0]         slot_q;
  logic [COUNT_W-1:0] count_q, bcnt_q;
  logic [1:0]         pad_q;
  logic               rd_q, ph_q, sck_q, cs_n_q, done_q;
  logic [3:0]         ucnt_q, oe_q;
  logic [DCW-1:0]     dcnt_q;
  logic [7:0]         sr_q;
  logic [15:0]        lut_instr;
  slot_t              cur;

  // named internal events
  logic start_acc, end_evt, byte_done, rx_push, tx_pop, tx_ready, rx_full;
  logic adv_last;
  logic [7:0] tx_head;
  logic tx_empty, tx_full, rx_empty;
  wire unused_bits = ^{start_word[31:28], start_word[23:COUNT_W], flag_wdata[31:1],
                       tx_empty, tx_full, rx_empty};

  assign cur       = slot_t'(lut_instr);
  assign start_acc = start_valid && (state_q == ST_IDLE);
  assign end_evt   = (state_q == ST_END);
  assign byte_done = (state_q == ST_XFER) && ph_q && (ucnt_q == 4'd1);
  assign rx_push   = byte_done && rd_q;
  assign tx_ready  = (state_q == ST_TXWAIT) && (int'(tx_level) >= TX_START_MIN);
  assign tx_pop    = tx_ready || (byte_done && !rd_q && (bcnt_q > COUNT_W'(1)));
  assign adv_last  = (slot_q == 3'd7);

  sfs_lut #(.NUM_SEQ(NUM_SEQ)) u_lut (
    .clk(clk), .rst_n(rst_n), .we(lut_we), .waddr(lut_waddr), .wdata(lut_wdata),
    .rd_seq(seq_q), .rd_slot(slot_q), .rd_instr(lut_instr));

  sfs_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(end_evt), .push(tx_push), .wdata(tx_wdata),
    .pop(tx_pop), .rdata(tx_head), .level(tx_level), .empty(tx_empty), .full(tx_full));

  sfs_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(1'b0), .push(rx_push), .wdata(sr_q),
    .pop(rx_pop), .rdata(rx_rdata), .level(rx_level), .empty(rx_empty), .full(rx_full));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      seq_q   <= '0;
      slot_q  <= '0;
      count_q <= '0;
      bcnt_q  <= '0;
      pad_q   <= '0;
      rd_q    <= 1'b0;
      ph_q    <= 1'b0;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      ucnt_q  <= '0;
      oe_q    <= '0;
      dcnt_q  <= '0;
      sr_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          sck_q <= 1'b0;
          if (start_acc) begin
            seq_q   <= start_word[24 +: SEQ_W];
            count_q <= start_word[COUNT_W-1:0];
            slot_q  <= '0;
            state_q <= ST_LOAD;
          end
        end
        ST_LOAD: begin
          ph_q <= 1'b0;
          case (cur.op)
            OPC_STOP: state_q <= ST_END;
            OPC_CMD, OPC_MODE: begin
              cs_n_q  <= 1'b0;
              sr_q    <= cur.arg;
              pad_q   <= cur.pad;
              oe_q    <= lane_mask(cur.pad);
              ucnt_q  <= clocks_per_byte(cur.pad);
              bcnt_q  <= COUNT_W'(1);
              rd_q    <= 1'b0;
              state_q <= ST_XFER;
            end
            OPC_DUMMY: begin
              cs_n_q <= 1'b0;
              oe_q   <= '0;
              dcnt_q <= dummy_clocks(cur.arg);
              if (dummy_clocks(cur.arg) != '0) state_q <= ST_DUMMY;
              else if (adv_last)               state_q <= ST_END;
              else                             slot_q  <= slot_q + 3'd1;
            end
            OPC_READ, OPC_WRITE: begin
              cs_n_q <= 1'b0;
              oe_q   <= '0;
              pad_q  <= cur.pad;
              ucnt_q <= clocks_per_byte(cur.pad);
              bcnt_q <= count_q;
              rd_q   <= (cur.op == OPC_READ);
              if (count_q != '0)  state_q <= (cur.op == OPC_READ) ? ST_XFER : ST_TXWAIT;
              else if (adv_last)  state_q <= ST_END;
              else                slot_q  <= slot_q + 3'd1;
            end
            default: begin
              if (adv_last) state_q <= ST_END;
              else          slot_q  <= slot_q + 3'd1;
            end
          endcase
        end
        ST_XFER: begin
          ph_q  <= !ph_q;
          sck_q <= !ph_q;
          if (!ph_q) begin
            if (rd_q) sr_q <= shift_in(sr_q, pad_q, io_in);
          end else if (ucnt_q > 4'd1) begin
            ucnt_q <= ucnt_q - 4'd1;
            if (!rd_q) sr_q <= shift_out(sr_q, pad_q);
          end else if (bcnt_q > COUNT_W'(1)) begin
            bcnt_q <= bcnt_q - COUNT_W'(1);
            ucnt_q <= clocks_per_byte(pad_q);
            if (!rd_q) sr_q <= tx_head;
          end else begin
            oe_q <= '0;
            if (adv_last) state_q <= ST_END;
            else begin
              slot_q  <= slot_q + 3'd1;
              state_q <= ST_LOAD;
            end
          end
        end
        ST_DUMMY: begin
          ph_q  <= !ph_q;
          sck_q <= !ph_q;
          if (ph_q) begin
            if (dcnt_q > DCW'(1)) dcnt_q <= dcnt_q - DCW'(1);
            else if (adv_last)    state_q <= ST_END;
            else begin
              slot_q  <= slot_q + 3'd1;
              state_q <= ST_LOAD;
            end
          end
        end
        ST_TXWAIT: begin
          if (tx_ready) begin
            sr_q    <= tx_head;
            oe_q    <= lane_mask(pad_q);
            state_q <= ST_XFER;
          end
        end
        ST_END: begin
          cs_n_q  <= 1'b1;
          sck_q   <= 1'b0;
          oe_q    <= '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                        done_q <= 1'b0;
    else if (end_evt)                  done_q <= 1'b1;
    else if (flag_we && flag_wdata[0]) done_q <= 1'b0;
  end

  assign done_flag = done_q;
  assign irq       = done_q && irq_en;
  assign busy      = (state_q != ST_IDLE);
  assign sck       = sck_q;
  assign cs_n      = cs_n_q;
  assign io_oe     = oe_q;
  assign io_out    = (oe_q != '0) ? lanes_out(sr_q, pad_q) : 4'b0000;

  // R3: serial clock only pulses inside a selected transaction
  a_r3_sck_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
    sck |-> !cs_n);
  // R3: serial clock high phase lasts exactly one system clock
  a_r3_sck_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    sck |=> !sck);
  // R2: start while running leaves the latched request alone
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_valid) |=> ($stable(seq_q) && $stable(count_q)));
  // R6: dummy counter never holds more than the cap
  a_r6_dummy_cap: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DUMMY) |-> (dcnt_q <= DCW'(MAX_DUMMY)));
  // R6/R7: no line is driven during dummy or read clocks
  a_r7_lines_released: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_DUMMY) || (state_q == ST_XFER && rd_q)) |-> (io_oe == 4'b0000));
  // R7: received bytes always find room
  a_r7_rx_room: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !rx_full);
  // R10: end of sequence leaves the flag set and the flash deselected
  a_r10_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    end_evt |=> (done_flag && cs_n && !busy));
  // R10: a clear with no competing end drops the flag
  a_r10_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && flag_wdata[0] && !end_evt) |=> !done_flag);
  // R8: leftover transmit bytes are gone once the sequence ends
  a_r8_tx_flushed: assert property (@(posedge clk) disable iff (!rst_n)
    (end_evt && !tx_push) |=> (tx_level == '0));

endmodule

// File: tb/flash_seq_engine_tb.sv
module flash_seq_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lut_we = 1'b0;
  logic [5:0]  lut_waddr = '0;
  logic [31:0] lut_wdata = '0;
  logic        start_valid = 1'b0;
  logic [31:0] start_word = '0;
  logic        flag_we = 1'b0;
  logic [31:0] flag_wdata = '0;
  logic        irq_en = 1'b0;
  logic        tx_push = 1'b0;
  logic [7:0]  tx_wdata = '0;
  logic [5:0]  tx_level, rx_level;
  logic        rx_pop = 1'b0;
  logic [7:0]  rx_rdata;
  logic        done_flag, irq, busy, sck, cs_n;
  logic [3:0]  io_out, io_oe;
  logic [3:0]  io_in = '0;

  always #10 clk = ~clk;

  flash_seq_engine u_dut (
    .clk(clk), .rst_n(rst_n), .lut_we(lut_we), .lut_waddr(lut_waddr), .lut_wdata(lut_wdata),
    .start_valid(start_valid), .start_word(start_word), .flag_we(flag_we),
    .flag_wdata(flag_wdata), .irq_en(irq_en), .tx_push(tx_push), .tx_wdata(tx_wdata),
    .tx_level(tx_level), .rx_pop(rx_pop), .rx_rdata(rx_rdata), .rx_level(rx_level),
    .done_flag(done_flag), .irq(irq), .busy(busy), .sck(sck), .cs_n(cs_n),
    .io_out(io_out), .io_oe(io_oe), .io_in(io_in));

  int n_checks = 0;
  int n_fail   = 0;
  int cs_falls = 0;
  logic prev_sck = 1'b0;
  logic prev_cs  = 1'b1;
  logic [3:0] q_oe[$], q_out[$], q_in[$];
  logic [7:0] q_rx[$];
  logic [15:0] pg[8];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model of the flash side: one expected entry per serial clock
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 sck idle while deselected", {31'b0, sck && cs_n}, 32'd0);
      if (sck && !prev_sck) begin
        if (q_oe.size() == 0) chk("R3 unexpected serial clock", 32'd1, 32'd0);
        else begin
          chk("R4 lane enables", {28'b0, io_oe}, {28'b0, q_oe.pop_front()});
          chk("R5 lane data", {28'b0, io_out}, {28'b0, q_out.pop_front()});
          void'(q_in.pop_front());
        end
      end
      if (!cs_n && prev_cs) cs_falls++;
      if (!sck) io_in = (q_in.size() != 0) ? q_in[0] : 4'b0000;
      prev_sck = sck;
      prev_cs  = cs_n;
    end
  end

  function automatic logic [15:0] ins(input int op, input int pad, input int arg);
    return {op[5:0], pad[1:0], arg[7:0]};
  endfunction

  function automatic int lane_w(input int pad);
    return (pad == 0) ? 1 : (pad == 1) ? 2 : 4;
  endfunction

  task automatic exp_byte(input logic [7:0] b, input int pad, input bit is_in);
    int w = lane_w(pad);
    for (int k = 0; k < 8 / w; k++) begin
      logic [3:0] v = 4'((int'(b) >> (8 - w * (k + 1))) & ((1 << w) - 1));
      q_oe.push_back(is_in ? 4'b0000 : 4'((1 << w) - 1));
      q_out.push_back(is_in ? 4'b0000 : v);
      q_in.push_back(!is_in ? 4'b0000 : (pad == 0) ? {2'b00, v[0], 1'b0} : v);
    end
    if (is_in) q_rx.push_back(b);
  endtask

  task automatic exp_dummy(input int n);
    for (int k = 0; k < n; k++) begin
      q_oe.push_back(4'b0000); q_out.push_back(4'b0000); q_in.push_back(4'b0000);
    end
  endtask

  task automatic clr_pg();
    for (int i = 0; i < 8; i++) pg[i] = 16'h0000;
  endtask

  task automatic load_seq(input int seq);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      lut_we = 1'b1; lut_waddr = 6'(seq * 4 + w); lut_wdata = {pg[2*w+1], pg[2*w]};
    end
    @(negedge clk); lut_we = 1'b0;
  endtask

  task automatic start(input int seq, input int count);
    @(negedge clk);
    start_valid = 1'b1; start_word = {4'h0, 4'(seq), 8'h00, 16'(count)};
    @(negedge clk);
    start_valid = 1'b0;
  endtask

  task automatic wait_done(input string tag);
    int t = 0;
    while (!done_flag && t < 5000) begin @(negedge clk); t++; end
    chk({tag, " done flag set"}, {31'b0, done_flag}, 32'd1);
    @(negedge clk);
    chk({tag, " all serial clocks seen"}, q_oe.size(), 0);
    chk({tag, " idle after end"}, {30'b0, busy, cs_n}, 32'd1);
  endtask

  task automatic clear_flag();
    @(negedge clk); flag_we = 1'b1; flag_wdata = 32'h1;
    @(negedge clk); flag_we = 1'b0; flag_wdata = 32'h0;
  endtask

  task automatic drain_rx(input string tag);
    chk({tag, " rx level"}, rx_level, q_rx.size());
    while (q_rx.size() != 0) begin
      chk({tag, " rx byte"}, rx_rdata, q_rx.pop_front());
      rx_pop = 1'b1; @(negedge clk); rx_pop = 1'b0; @(negedge clk);
    end
  endtask

  task automatic push_tx(input logic [7:0] b);
    @(negedge clk); tx_push = 1'b1; tx_wdata = b;
    @(negedge clk); tx_push = 1'b0;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finish_run();
  end

  initial begin
    int falls_before;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset outputs", {26'b0, cs_n, sck, io_oe != 4'b0, done_flag, irq, busy}, 32'h20);
    chk("R11 reset fifo levels", {tx_level, rx_level}, 32'd0);

    // R1 R5 R7 single-line command then read of 3 bytes
    clr_pg(); pg[0] = ins(1, 0, 8'h9F); pg[1] = ins(7, 0, 8'h00); load_seq(1);
    exp_byte(8'h9F, 0, 0); exp_byte(8'hC2, 0, 1); exp_byte(8'h20, 0, 1); exp_byte(8'h5A, 0, 1);
    start(1, 3); wait_done("R7 single read"); drain_rx("R7 single read"); clear_flag();
    chk("R10 flag cleared", {31'b0, done_flag}, 32'd0);

    // R4 R6 R7 addressed quad read, operand of read ignored
    clr_pg();
    pg[0] = ins(1, 0, 8'h6B); pg[1] = ins(4, 0, 8'h12); pg[2] = ins(4, 0, 8'h34);
    pg[3] = ins(4, 0, 8'h56); pg[4] = ins(3, 2, 8); pg[5] = ins(7, 2, 8'h99);
    load_seq(2);
    exp_byte(8'h6B, 0, 0); exp_byte(8'h12, 0, 0); exp_byte(8'h34, 0, 0); exp_byte(8'h56, 0, 0);
    exp_dummy(8);
    exp_byte(8'hA5, 2, 1); exp_byte(8'h3C, 2, 1); exp_byte(8'hF0, 2, 1); exp_byte(8'h0F, 2, 1);
    start(2, 4); wait_done("R4 quad read"); drain_rx("R7 quad read"); clear_flag();

    // R4 R8 write with dual address, waits for 16 TX bytes
    clr_pg();
    pg[0] = ins(1, 0, 8'h32); pg[1] = ins(4, 1, 8'h00); pg[2] = ins(4, 1, 8'h10);
    pg[3] = ins(8, 2, 8'h77);
    load_seq(3);
    exp_byte(8'h32, 0, 0); exp_byte(8'h00, 1, 0); exp_byte(8'h10, 1, 0);
    exp_byte(8'hDE, 2, 0); exp_byte(8'hAD, 2, 0); exp_byte(8'hBE, 2, 0);
    exp_byte(8'hEF, 2, 0); exp_byte(8'h42, 2, 0);
    push_tx(8'hDE); push_tx(8'hAD); push_tx(8'hBE); push_tx(8'hEF); push_tx(8'h42);
    start(3, 5);
    repeat (200) @(negedge clk);
    chk("R8 write held below threshold", q_oe.size(), 10);
    chk("R8 still busy", {31'b0, busy}, 32'd1);
    for (int i = 0; i < 11; i++) push_tx(8'hEE);
    wait_done("R8 write");
    chk("R8 leftover tx discarded", tx_level, 0);
    clear_flag();

    // R9 eight slots without stop, dual lane commands
    clr_pg();
    for (int i = 0; i < 8; i++) begin
      pg[i] = ins(1, 1, 8'h10 + i); exp_byte(8'(8'h10 + i), 1, 0);
    end
    load_seq(4); start(4, 0); wait_done("R9 eighth slot end"); clear_flag();

    // R9 stop in first slot (sequence 5 never written): no select
    falls_before = cs_falls;
    start(5, 0); wait_done("R9 immediate stop");
    chk("R3 no select on empty sequence", cs_falls, falls_before);
    clear_flag();

    // R6 dummy cap at 64 clocks, pad code 3 behaves as quad
    clr_pg(); pg[0] = ins(1, 3, 8'hAA); pg[1] = ins(3, 0, 100); load_seq(6);
    exp_byte(8'hAA, 2, 0); exp_dummy(64);
    start(6, 0); wait_done("R6 dummy cap"); clear_flag();

    // R7 R9 zero count skips data slot, unknown opcode skipped
    clr_pg();
    pg[0] = ins(1, 0, 8'h05); pg[1] = ins(7, 0, 8'h04); pg[2] = ins(5, 0, 8'hFF);
    pg[3] = ins(1, 1, 8'h06);
    load_seq(7);
    exp_byte(8'h05, 0, 0); exp_byte(8'h06, 1, 0);
    start(7, 0); wait_done("R9 skip slots");
    chk("R7 zero count reads nothing", rx_level, 0);
    clear_flag();

    // R4 dual read, R10 interrupt gating
    clr_pg(); pg[0] = ins(1, 0, 8'h3B); pg[1] = ins(7, 1, 8'h00); load_seq(8);
    exp_byte(8'h3B, 0, 0); exp_byte(8'h96, 1, 1); exp_byte(8'h4D, 1, 1);
    irq_en = 1'b1;
    start(8, 2); wait_done("R4 dual read");
    chk("R10 irq when enabled", {31'b0, irq}, 32'd1);
    irq_en = 1'b0; @(negedge clk);
    chk("R10 irq masked", {31'b0, irq}, 32'd0);
    drain_rx("R4 dual read"); clear_flag();
    irq_en = 1'b1; @(negedge clk);
    chk("R10 irq low after clear", {31'b0, irq}, 32'd0);
    irq_en = 1'b0;

    // R2 start during a run is ignored
    exp_byte(8'h9F, 0, 0); exp_byte(8'h11, 0, 1); exp_byte(8'h22, 0, 1); exp_byte(8'h33, 0, 1);
    start(1, 3);
    repeat (10) @(negedge clk);
    start(4, 0);
    wait_done("R2 start while busy");
    repeat (60) @(negedge clk);
    chk("R2 no second run", {31'b0, busy}, 32'd0);
    drain_rx("R2 start while busy"); clear_flag();

    finish_run();
  end
endmodule